// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This unit keeps the five 32-bit machine-level control registers of a small in-order core: the interrupt-enable mask, the trap vector base, a scratch word, the saved exception program counter and the trap cause. The execute stage presents a 12-bit register address, a 3-bit operation code and two candidate operands: the value of a source register and a zero-extended immediate. It raises a write strobe for one cycle to commit the operation. The read port returns the addressed register with no clock delay, so that the core can retire the old value to its destination register in the same cycle that the update is committed.

The operations are write, set-bits and clear-bits, each in a register-operand form and an immediate-operand form. A separate trap input captures the faulting program counter and the cause code together on one clock edge, independently of the write strobe. Three of the registers (interrupt enable, exception PC and trap vector) are also driven continuously to the rest of the core on dedicated outputs.

Top module: `csr_unit`

## Requirements
- R1: A synchronous active-low reset clears all five registers to zero, so every mapped address reads 0 and all three dedicated outputs are 0 on the cycle after the reset edge.
- R2: The write codes store the operand unchanged: op 3'b001 stores `rs1_val` and op 3'b101 stores `imm_val` into the addressed register.
- R3: The set codes store the old value ORed with the operand: op 3'b010 uses `rs1_val` and op 3'b110 uses `imm_val`.
- R4: The clear codes store the old value ANDed with the inverted operand: op 3'b011 uses `rs1_val` and op 3'b111 uses `imm_val`.
- R5: A register changes only on a rising clock edge where `wr_en` is 1, and the new value is on `rd_data` from the next cycle. With `wr_en` at 0, no operation code, address or operand changes any register.
- R6: The codes 3'b000 and 3'b100 leave every register unchanged, even when `wr_en` is 1.
- R7: The register map is 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception PC and 0x342 cause. Any other address reads as 0, and a write to it changes no register.
- R8: When `trap_req` is 1 on a rising edge, the exception PC takes `trap_pc` and the cause register takes `trap_cause` on that edge. Both values are visible on the next cycle.
- R9: When `trap_req` and `wr_en` are both 1, the trap values win for the exception PC and cause registers and the write to those two registers is dropped. A write to any of the other three registers in that cycle still takes effect.
- R10: `irq_en_o`, `epc_o` and `tvec_o` always equal the current interrupt-enable, exception-PC and trap-vector registers.
- R11: `rd_data` is combinational from `csr_addr`. In the cycle a write is strobed it shows the old value, which is the value the update is computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Commit strobe for the operation |
| op | input | 3 | Operation code (see R2 to R4, R6) |
| csr_addr | input | 12 | Register address for read and write |
| rs1_val | input | 32 | Register operand |
| imm_val | input | 32 | Immediate operand, already extended |
| trap_req | input | 1 | Capture trap PC and cause this edge |
| trap_pc | input | 32 | Program counter of the trapping instruction |
| trap_cause | input | 32 | Cause code to record |
| rd_data | output | 32 | Contents of the addressed register |
| irq_en_o | output | 32 | Interrupt-enable register |
| epc_o | output | 32 | Exception PC register |
| tvec_o | output | 32 | Trap vector register |

## Verification
Reads are due in the same cycle as the address, and every write or trap result is due exactly one rising edge after the strobe. The bench drives all inputs on the falling edge, holds each strobe across exactly one rising edge, and then reads back at the following falling edge. The old-value read is sampled before the committing edge, while the strobe is still high. Reset, hold, no-op and unmapped-address cases read back every mapped register and all three dedicated outputs after the stimulus, to show that nothing moved.

// File: rtl/csr_unit_pkg.sv
// Package: shared constants, operation codes and the address map for the
// machine-mode register unit. Assumes 12-bit register addresses.
package csr_unit_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int CSR_COUNT  = 5;

    // Operation codes: bit 2 selects immediate, bits 1:0 select the action
    typedef enum logic [2:0] {
        OP_NONE   = 3'b000,
        OP_WR     = 3'b001,
        OP_SET    = 3'b010,
        OP_CLR    = 3'b011,
        OP_NONE_I = 3'b100,
        OP_WR_I   = 3'b101,
        OP_SET_I  = 3'b110,
        OP_CLR_I  = 3'b111
    } csr_op_e;

    // Storage slot indices
    localparam int IDX_IRQ_EN  = 0;
    localparam int IDX_TVEC    = 1;
    localparam int IDX_SCRATCH = 2;
    localparam int IDX_EPC     = 3;
    localparam int IDX_CAUSE   = 4;

    // Address of each storage slot
    function automatic logic [CSR_ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            IDX_IRQ_EN:  return 12'h304;
            IDX_TVEC:    return 12'h305;
            IDX_SCRATCH: return 12'h340;
            IDX_EPC:     return 12'h341;
            IDX_CAUSE:   return 12'h342;
            default:     return 12'h000;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
// Module: address decoder. Turns a register address into a one-hot slot
// select plus a hit flag. Assumes the map in csr_unit_pkg has distinct entries.
module csr_addr_decode
    import csr_unit_pkg::*;
#(
    parameter int ADDR_W = CSR_ADDR_W,
    parameter int SLOTS  = CSR_COUNT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOTS-1:0]  sel,
    output logic              hit
);

    // One comparator per slot
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_cmp
        assign sel[gi] = (addr == ADDR_W'(slot_addr(gi)));
    end

    assign hit = |sel;

    // At most one slot may match any address
    always_comb begin
        assert_sel_onehot_R7: assert ($onehot0(sel));
    end

endmodule

// File: rtl/csr_rmw_alu.sv
// Module: read-modify-write datapath. Picks the operand, applies the
// write/set/clear action to the old value and flags codes that modify.
// Assumes op is a csr_op_e value; pure combinational.
module csr_rmw_alu
    import csr_unit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  csr_op_e           op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] rs1_val,
    input  logic [DATA_W-1:0] imm_val,
    output logic [DATA_W-1:0] new_val,
    output logic              modifies
);

    logic [DATA_W-1:0] operand;

    // Operand source selected by the immediate bit of the code
    assign operand = op[2] ? imm_val : rs1_val;

    // Action selected by the low two bits of the code
    always_comb begin
        modifies = 1'b1;
        case (op[1:0])
            2'b01:   new_val = operand;
            2'b10:   new_val = old_val | operand;
            2'b11:   new_val = old_val & ~operand;
            default: begin
                new_val  = old_val;
                modifies = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csr_unit.sv
// Module: machine-mode control/status register unit. Five registers with a
// combinational read port, a strobed read-modify-write port and a trap
// capture path into the exception PC and cause slots. Trap wins over a
// write for those two slots. Assumes single-cycle strobes from the core.
module csr_unit
    import csr_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = CSR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] rs1_val,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              trap_req,
    input  logic [DATA_W-1:0] trap_pc,
    input  logic [DATA_W-1:0] trap_cause,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] irq_en_o,
    output logic [DATA_W-1:0] epc_o,
    output logic [DATA_W-1:0] tvec_o
);

    localparam int SLOTS = CSR_COUNT;

    logic [DATA_W-1:0] csr_q [SLOTS];
    logic [SLOTS-1:0]  sel;
    logic              hit;
    logic [DATA_W-1:0] new_val;
    logic              modifies;
    logic              commit;

    csr_addr_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_dec (
        .addr (csr_addr),
        .sel  (sel),
        .hit  (hit)
    );

    // Read mux: OR of the selected slot, zero when nothing matches
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (sel[i]) rd_data = rd_data | csr_q[i];
        end
    end

    csr_rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (csr_op_e'(op)),
        .old_val  (rd_data),
        .rs1_val  (rs1_val),
        .imm_val  (imm_val),
        .new_val  (new_val),
        .modifies (modifies)
    );

    assign commit = wr_en & modifies & hit;

    // One storage slot per register; trap targets get the capture path
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        if (gi == IDX_EPC || gi == IDX_CAUSE) begin : g_trap_dst
            logic [DATA_W-1:0] cap_val;
            assign cap_val = (gi == IDX_EPC) ? trap_pc : trap_cause;
            // Trap capture first, otherwise normal write
            always_ff @(posedge clk) begin
                if (!rst_n)                  csr_q[gi] <= '0;
                else if (trap_req)           csr_q[gi] <= cap_val;
                else if (commit && sel[gi])  csr_q[gi] <= new_val;
            end
        end else begin : g_plain
            // Normal write only
            always_ff @(posedge clk) begin
                if (!rst_n)                  csr_q[gi] <= '0;
                else if (commit && sel[gi])  csr_q[gi] <= new_val;
            end
        end
    end

    assign irq_en_o = csr_q[IDX_IRQ_EN];
    assign epc_o    = csr_q[IDX_EPC];
    assign tvec_o   = csr_q[IDX_TVEC];

    // Registers are zero on the first cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_en_o == '0 && epc_o == '0 && tvec_o == '0 &&
                          csr_q[IDX_SCRATCH] == '0 && csr_q[IDX_CAUSE] == '0));

    // No strobe, no change
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !trap_req) |=> ($stable(irq_en_o) && $stable(epc_o) &&
                                   $stable(tvec_o)));

    // No-op codes never change state
    assert_nop_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_req && (op == 3'b000 || op == 3'b100)) |=>
            ($stable(irq_en_o) && $stable(epc_o) && $stable(tvec_o)));

    // Trap captures PC and cause on the same edge
    assert_trap_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epc_o == $past(trap_pc) &&
                      csr_q[IDX_CAUSE] == $past(trap_cause)));

    // Simultaneous write to the cause slot is dropped in favour of the trap
    assert_trap_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && wr_en && csr_addr == 12'h342) |=>
            (csr_q[IDX_CAUSE] == $past(trap_cause)));

endmodule

// File: tb/csr_unit_test.sv
module csr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [11:0] csr_addr = 12'h000;
    logic [31:0] rs1_val = '0;
    logic [31:0] imm_val = '0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_cause = '0;
    logic [31:0] rd_data, irq_en_o, epc_o, tvec_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] model [5];

    always #2 clk = ~clk;

    csr_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(op), .csr_addr(csr_addr),
        .rs1_val(rs1_val), .imm_val(imm_val), .trap_req(trap_req),
        .trap_pc(trap_pc), .trap_cause(trap_cause), .rd_data(rd_data),
        .irq_en_o(irq_en_o), .epc_o(epc_o), .tvec_o(tvec_o)
    );

    // Map per R7: 0 irq enable, 1 vector, 2 scratch, 3 epc, 4 cause
    function automatic logic [11:0] a_of(input int i);
        case (i)
            0: return 12'h304;
            1: return 12'h305;
            2: return 12'h340;
            3: return 12'h341;
            default: return 12'h342;
        endcase
    endfunction

    function automatic int idx_of(input logic [11:0] a);
        for (int i = 0; i < 5; i++) if (a_of(i) == a) return i;
        return -1;
    endfunction

    // Expected result per R2, R3, R4, R6
    function automatic logic [31:0] apply(input logic [2:0] c, input logic [31:0] old,
                                          input logic [31:0] r, input logic [31:0] im);
        logic [31:0] v;
        v = c[2] ? im : r;
        case (c[1:0])
            2'b01:   return v;
            2'b10:   return old | v;
            2'b11:   return old & ~v;
            default: return old;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Read back every slot and the dedicated outputs (R10)
    task automatic verify_all(input string req);
        for (int i = 0; i < 5; i++) begin
            csr_addr = a_of(i);
            #0.5;
            chk(req, $sformatf("read %h", a_of(i)), rd_data, model[i]);
        end
        chk("R10", "irq_en_o", irq_en_o, model[0]);
        chk("R10", "tvec_o", tvec_o, model[1]);
        chk("R10", "epc_o", epc_o, model[3]);
    endtask

    // One strobed operation; also checks the old value before the edge (R11)
    task automatic do_op(input logic [2:0] c, input logic [11:0] a,
                         input logic [31:0] r, input logic [31:0] im);
        int k;
        @(negedge clk);
        op = c; csr_addr = a; rs1_val = r; imm_val = im; wr_en = 1'b1;
        k = idx_of(a);
        #0.5;
        chk("R11", "old value before commit", rd_data, (k < 0) ? 32'h0 : model[k]);
        @(negedge clk);
        wr_en = 1'b0; op = 3'b000;
        if (k >= 0) model[k] = apply(c, model[k], r, im);
    endtask

    task automatic t_reset_state;
        verify_all("R1");
    endtask

    task automatic t_write;
        do_op(3'b001, 12'h304, 32'hA5A5_0F0F, 32'h1111_1111);
        do_op(3'b001, 12'h305, 32'h8000_0100, 32'h0);
        do_op(3'b101, 12'h340, 32'hDEAD_BEEF, 32'h0000_001F);
        do_op(3'b001, 12'h341, 32'h0000_2004, 32'h0);
        do_op(3'b101, 12'h342, 32'h0, 32'h0000_000B);
        verify_all("R2");
    endtask

    task automatic t_set;
        do_op(3'b010, 12'h304, 32'h5A5A_F0F0, 32'h0);
        do_op(3'b110, 12'h340, 32'h0, 32'h0000_0C00);
        verify_all("R3");
    endtask

    task automatic t_clear;
        do_op(3'b011, 12'h304, 32'h0F0F_00FF, 32'hFFFF_FFFF);
        do_op(3'b111, 12'h340, 32'hFFFF_FFFF, 32'h0000_000F);
        verify_all("R4");
    endtask

    task automatic t_hold;
        @(negedge clk);
        op = 3'b001; csr_addr = 12'h305; rs1_val = 32'h1234_5678; imm_val = 32'h9;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        op = 3'b000;
        verify_all("R5");
    endtask

    task automatic t_nop;
        do_op(3'b000, 12'h304, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_op(3'b100, 12'h305, 32'h0, 32'hFFFF_FFFF);
        verify_all("R6");
    endtask

    task automatic t_unmapped;
        do_op(3'b001, 12'h300, 32'hFFFF_FFFF, 32'h0);
        do_op(3'b110, 12'h343, 32'h0, 32'hFFFF_FFFF);
        csr_addr = 12'h300;
        #0.5;
        chk("R7", "unmapped read", rd_data, 32'h0);
        verify_all("R7");
    endtask

    task automatic t_trap;
        @(negedge clk);
        trap_req = 1'b1; trap_pc = 32'h0000_0A3C; trap_cause = 32'h8000_0007;
        @(negedge clk);
        trap_req = 1'b0;
        model[3] = 32'h0000_0A3C; model[4] = 32'h8000_0007;
        chk("R8", "epc_o after trap", epc_o, 32'h0000_0A3C);
        verify_all("R8");
    endtask

    task automatic t_priority;
        // Write to cause together with trap: trap wins
        @(negedge clk);
        trap_req = 1'b1; trap_pc = 32'h0000_4440; trap_cause = 32'h0000_0002;
        wr_en = 1'b1; op = 3'b001; csr_addr = 12'h342; rs1_val = 32'hFFFF_0000;
        @(negedge clk);
        trap_req = 1'b0; wr_en = 1'b0; op = 3'b000;
        model[3] = 32'h0000_4440; model[4] = 32'h0000_0002;
        verify_all("R9");
        // Write to exception PC together with trap: trap wins
        @(negedge clk);
        trap_req = 1'b1; trap_pc = 32'h0000_5550; trap_cause = 32'h0000_0003;
        wr_en = 1'b1; op = 3'b101; csr_addr = 12'h341; imm_val = 32'h0000_0019;
        @(negedge clk);
        trap_req = 1'b0; wr_en = 1'b0; op = 3'b000;
        model[3] = 32'h0000_5550; model[4] = 32'h0000_0003;
        verify_all("R9");
        // Write to scratch together with trap: both land
        @(negedge clk);
        trap_req = 1'b1; trap_pc = 32'h0000_6660; trap_cause = 32'h0000_0005;
        wr_en = 1'b1; op = 3'b001; csr_addr = 12'h340; rs1_val = 32'hCAFE_F00D;
        @(negedge clk);
        trap_req = 1'b0; wr_en = 1'b0; op = 3'b000;
        model[2] = 32'hCAFE_F00D; model[3] = 32'h0000_6660; model[4] = 32'h0000_0005;
        verify_all("R9");
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) model[i] = '0;
        verify_all("R1");
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write();
        t_set();
        t_clear();
        t_hold();
        t_nop();
        t_unmapped();
        t_trap();
        t_priority();
        t_reset_again();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #40000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule